// File: doc/BRIEF.md
# Circular-Buffer FIR Tap Engine

This block is a small finite impulse response filter. Each accepted sample is written into a power-of-two ring of history registers. The filter then walks that ring from the newest entry to the oldest and completes one multiply-accumulate per clock. History data never moves. A write pointer advances once per sample and a read pointer steps backward, and both wrap on their low address bits. The coefficients sit in a separate linear bank that is indexed by tap number. This bank can be rewritten through a simple write port and comes out of reset holding 2, 3, 4 and 5.

Products are 16 × 16 signed. The block adds them into a 40-bit accumulator that saturates rather than wraps. The accumulator is cleared whenever a new sample is accepted. When the last tap completes, the saturated sum is clamped to the signed 16-bit range and presented for exactly one cycle. While a computation runs, the block drops its ready signal, so an upstream source holds its next sample.

Top module: `fir_circ_engine`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0, every history entry is zero, and coefficient k (k = 0..3) holds 2 + k. The first output is therefore 2·x(0).
- R2: A sample is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the cycle after acceptance until the cycle in which `out_valid` rises, `in_ready` is 0, and any `in_valid` pulse in that window leaves the history unchanged.
- R3: `out_valid` is high for exactly one cycle, in the cycle that begins with the fourth rising edge after the accepting edge.
- R4: The output for sample n is Σ c[k]·x(n−k) for k = 0..3, where `coef_addr` value k selects c[k] and unwritten history counts as zero.
- R5: The history behaves as a four-entry circular buffer. Each new sample overwrites the oldest, so outputs stay correct after any number of samples.
- R6: When `coef_we` is 1 on a rising edge, `coef_wdata` is written to coefficient `coef_addr`. Computations that start after the write use the new value.
- R7: `out_data` is the accumulator clamped to [−32768, 32767]. Sums above the range give 32767 and sums below it give −32768.
- R8: Products are added from the newest tap to the oldest. Each addition saturates at the accumulator width (default 40 bits) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | 16 | Signed input sample |
| in_ready | output | 1 | Engine idle and able to accept a sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 2 | Tap index of the coefficient written |
| coef_wdata | input | 16 | Signed coefficient value |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed filtered sample |

## Verification
The in-line assertions check the following on every cycle:
- `in_ready` falls right after an acceptance.
- `out_valid` never lasts two cycles.
- A result only follows a running tap sequence.
- The ring's read port returns the sample just written.
- A saturated accumulator stays pinned when a non-negative product arrives.

Only the bench's scenarios can show the rest:
- Arithmetic correctness against the tap formula.
- Wrap of the ring over many samples.
- The effect of coefficient rewrites.
- Output clamping in both directions.
- Accumulator saturation. This needs a second instance built with a 32-bit accumulator, because 40 bits cannot overflow with four taps.

// File: rtl/fir_circ_pkg.sv
package fir_circ_pkg;
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } fir_state_e;
endpackage

// File: rtl/fir_ring.sv
module fir_ring #(
   parameter int DATA_W = 16,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              step,
   output logic [DATA_W-1:0] rd_data
);
   localparam int AW = $clog2(DEPTH);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("fir_ring: DEPTH must be a power of two");
   end

   logic [DATA_W-1:0] slots [DEPTH];
   logic [AW-1:0]     wptr;
   logic [AW-1:0]     rptr;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slots[i] <= '0;
         else if (wr_en && wptr == AW'(i))
            slots[i] <= wr_data;
      end
   end

   // post-increment writer, post-decrement reader; wrap comes from the width
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
      end else if (wr_en) begin
         wptr <= wptr + 1'b1;
         rptr <= wptr;
      end else if (step) begin
         rptr <= rptr - 1'b1;
      end
   end

   assign rd_data = slots[rptr];

   AST_NEWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == $past(wr_data)) else $error("newest sample not first"); // R5
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
   parameter int COEF_W    = 16,
   parameter int TAPS      = 4,
   parameter int COEF_BASE = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [$clog2(TAPS)-1:0]  waddr,
   input  logic [COEF_W-1:0]        wdata,
   input  logic [$clog2(TAPS)-1:0]  raddr,
   output logic [COEF_W-1:0]        rdata
);
   localparam int IW = $clog2(TAPS);

   logic [COEF_W-1:0] bank [TAPS];

   for (genvar k = 0; k < TAPS; k++) begin : g_coef
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bank[k] <= COEF_W'(COEF_BASE + k);
         else if (we && waddr == IW'(k))
            bank[k] <= wdata;
      end
   end

   assign rdata = bank[raddr];
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
   parameter int DATA_W = 16,
   parameter int COEF_W = 16,
   parameter int ACC_W  = 40,
   parameter bit SAT_EN = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic                     en,
   input  logic signed [DATA_W-1:0] a,
   input  logic signed [COEF_W-1:0] b,
   output logic signed [ACC_W-1:0]  acc_next,
   output logic signed [ACC_W-1:0]  acc_q
);
   localparam int PW = DATA_W + COEF_W;
   localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   if (ACC_W < PW) begin : g_bad_acc
      $error("fir_mac: ACC_W must hold a full product");
   end

   logic signed [PW-1:0]  prod;
   logic signed [ACC_W:0] sum;

   assign prod = a * b;
   assign sum  = {acc_q[ACC_W-1], acc_q} + (ACC_W+1)'(prod);

   if (SAT_EN) begin : g_sat
      always_comb begin
         if (sum[ACC_W] != sum[ACC_W-1])
            acc_next = sum[ACC_W] ? ACC_MIN : ACC_MAX;
         else
            acc_next = sum[ACC_W-1:0];
      end
   end else begin : g_wrap
      assign acc_next = sum[ACC_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clr)
         acc_q <= '0;
      else if (en)
         acc_q <= acc_next;
   end

   if (SAT_EN) begin : g_sat_chk
      AST_SAT_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
         (en && !clr && acc_q == ACC_MAX && prod >= 0) |=> acc_q == ACC_MAX)
         else $error("accumulator left saturation"); // R8
   end
endmodule

// File: rtl/fir_circ_engine.sv
module fir_circ_engine #(
   parameter int DATA_W    = 16,
   parameter int COEF_W    = 16,
   parameter int ACC_W     = 40,
   parameter int OUT_W     = 16,
   parameter int TAPS      = 4,
   parameter int COEF_BASE = 2,
   parameter bit SAT_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              coef_we,
   input  logic [$clog2(TAPS)-1:0] coef_addr,
   input  logic [COEF_W-1:0] coef_wdata,
   output logic              out_valid,
   output logic [OUT_W-1:0]  out_data
);
   import fir_circ_pkg::*;

   localparam int TW = $clog2(TAPS);
   localparam logic [TW-1:0] LAST_TAP = TW'(TAPS - 1);
   localparam logic signed [ACC_W-1:0] OUT_MAX =
      {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
   localparam logic signed [ACC_W-1:0] OUT_MIN =
      {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

   if (TAPS < 2) begin : g_bad_taps
      $error("fir_circ_engine: TAPS must be at least 2");
   end
   if (OUT_W > ACC_W) begin : g_bad_out
      $error("fir_circ_engine: OUT_W exceeds ACC_W");
   end

   fir_state_e state;
   logic [TW-1:0] tap;
   logic accept, running, last;
   logic [DATA_W-1:0] smp;
   logic [COEF_W-1:0] cof;
   logic signed [ACC_W-1:0] acc_next, acc_q;
   logic signed [ACC_W-1:0] clamp_src;
   logic [OUT_W-1:0] clamped;

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign running  = (state == ST_RUN);
   assign last     = running && (tap == LAST_TAP);

   fir_ring #(.DATA_W(DATA_W), .DEPTH(TAPS)) u_ring (
      .clk(clk), .rst_n(rst_n),
      .wr_en(accept), .wr_data(in_data),
      .step(running), .rd_data(smp)
   );

   fir_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .COEF_BASE(COEF_BASE)) u_coef (
      .clk(clk), .rst_n(rst_n),
      .we(coef_we), .waddr(coef_addr), .wdata(coef_wdata),
      .raddr(tap), .rdata(cof)
   );

   fir_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W), .SAT_EN(SAT_EN)) u_mac (
      .clk(clk), .rst_n(rst_n),
      .clr(accept), .en(running),
      .a(signed'(smp)), .b(signed'(cof)),
      .acc_next(acc_next), .acc_q(acc_q)
   );

   assign clamp_src = acc_next;
   always_comb begin
      if (clamp_src > OUT_MAX)
         clamped = OUT_MAX[OUT_W-1:0];
      else if (clamp_src < OUT_MIN)
         clamped = OUT_MIN[OUT_W-1:0];
      else
         clamped = clamp_src[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tap   <= '0;
      end else if (accept) begin
         state <= ST_RUN;
         tap   <= '0;
      end else if (last) begin
         state <= ST_IDLE;
         tap   <= '0;
      end else if (running) begin
         tap   <= tap + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= last;
         if (last)
            out_data <= clamped;
      end
   end

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !in_ready) else $error("ready stayed high after accept"); // R2
   AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid) else $error("result strobe too long"); // R3
   AST_RESULT_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> $past(running)) else $error("result without taps"); // R3
   AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> acc_q == '0) else $error("accumulator not cleared"); // R4
endmodule

// File: tb/test_fir_circ_engine.sv
module test_fir_circ_engine;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic coef_we = 1'b0;
   logic [1:0] coef_addr = '0;
   logic [15:0] coef_wdata = '0;
   logic in_ready, out_valid, in_ready_n, out_valid_n;
   logic [15:0] out_data, out_data_n;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   longint hist [4];
   longint cf [4];
   int wp = 0;

   longint exp_w [$];
   longint exp_n [$];
   int     exp_c [$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   fir_circ_engine i_fir_circ_engine (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .out_valid(out_valid), .out_data(out_data));

   // narrow accumulator copy so that saturation becomes observable
   fir_circ_engine #(.ACC_W(32)) i_fir_circ_engine_n (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready_n), .coef_we(coef_we), .coef_addr(coef_addr),
      .coef_wdata(coef_wdata), .out_valid(out_valid_n), .out_data(out_data_n));

   task automatic check(input bit ok, input string req, input longint act, input longint expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic longint sat_add(input longint a, input longint p, input int w);
      longint mx, mn, s;
      mx = (longint'(1) <<< (w - 1)) - 1;
      mn = -(longint'(1) <<< (w - 1));
      s = a + p;
      if (s > mx) return mx;
      if (s < mn) return mn;
      return s;
   endfunction

   function automatic longint clamp16(input longint v);
      if (v > 32767) return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic model_push(input logic [15:0] s);
      longint aw, an, x;
      hist[wp] = longint'($signed(s));
      aw = 0; an = 0;
      for (int k = 0; k < 4; k++) begin
         x = hist[(wp - k + 4) % 4];
         aw = sat_add(aw, x * cf[k], 40);
         an = sat_add(an, x * cf[k], 32);
      end
      wp = (wp + 1) % 4;
      exp_w.push_back(clamp16(aw));
      exp_n.push_back(clamp16(an));
      exp_c.push_back(cyc + 5);
   endtask

   task automatic send(input logic [15:0] s, input int junk);
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_data  = s;
      model_push(s);
      @(negedge clk);
      check(in_ready == 1'b0, "R2 ready low after accept", in_ready, 0);
      for (int j = 0; j < junk; j++) begin
         in_data = 16'h5A5A;
         check(in_ready == 1'b0, "R2 ready low while busy", in_ready, 0);
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic set_coef(input int k, input longint v);
      @(negedge clk);
      coef_we = 1'b1;
      coef_addr = 2'(k);
      coef_wdata = 16'(v);
      cf[k] = v;
      @(negedge clk);
      coef_we = 1'b0;
   endtask

   bit prev_v = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (out_valid) begin
            if (exp_w.size() == 0) begin
               check(1'b0, "R3 unexpected result", 1, 0);
            end else begin
               longint ew, en;
               int ec;
               ew = exp_w.pop_front();
               en = exp_n.pop_front();
               ec = exp_c.pop_front();
               check(longint'($signed(out_data)) == ew, "R4 filtered value", $signed(out_data), ew);
               check(longint'($signed(out_data_n)) == en, "R8 narrow saturated value", $signed(out_data_n), en);
               check(cyc == ec, "R3 latency", cyc, ec);
            end
         end
         if (out_valid && prev_v) check(1'b0, "R3 pulse width", 2, 1);
         prev_v = out_valid;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic drain();
      int guard = 0;
      while (exp_w.size() != 0 && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      for (int k = 0; k < 4; k++) begin hist[k] = 0; cf[k] = 2 + k; end
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
      check(out_valid == 1'b0, "R1 reset out_valid", out_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);

      // R1: defaults 2,3,4,5 and zero history
      send(16'd100, 0);
      // R4: mixed signs
      send(-16'sd7, 0);
      send(16'd3, 0);
      send(16'd1000, 0);
      // R5: keep going past the wrap point
      for (int i = 0; i < 6; i++) send(16'(i * 37 - 90), 0);
      drain();
      // R2: junk offered while busy must not land in the history
      send(16'd11, 3);
      send(16'd22, 2);
      send(16'd33, 0);
      drain();
      // R6: rewrite coefficients
      set_coef(0, 1);
      set_coef(1, -1);
      set_coef(2, 0);
      set_coef(3, 7);
      for (int i = 0; i < 5; i++) send(16'(i * 500 - 1000), 0);
      drain();
      // R7: clamp high and low
      for (int k = 0; k < 4; k++) set_coef(k, 32767);
      for (int i = 0; i < 4; i++) send(16'd32767, 0);
      for (int i = 0; i < 4; i++) send(16'h8000, 0);
      drain();
      // R8: narrow accumulator overflows and must saturate
      for (int k = 0; k < 4; k++) set_coef(k, -32768);
      for (int i = 0; i < 4; i++) send(16'h8000, 0);
      drain();
      check(exp_w.size() == 0, "R3 all results seen", exp_w.size(), 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule